// File: doc/BRIEF.md
# Video sync word position monitor

This block sits on a 10-bit parallel digital video word stream, one word per clock, and looks for timing reference sequences: three preamble words (3FFh, 000h, 000h) followed by a status word whose bit 6 tells an end-of-active-video sequence (bit 6 = 1) from a start-of-active-video one (bit 6 = 0). For every sequence found it pulses a matching indicator output in the same cycle as the status word leaves on the delayed data output.

A line position counter, wrapping at a parameterised line length, predicts where the two sequences of each line must land: the end-of-active-video status word at position 0 and the start-of-active-video status word at position `SAV_POS`. A sequence that shows up while the monitor has no lock, or that the counter does not predict, raises a sticky out-of-place flag. The flag stays up for at least one line length in words, restarts that hold whenever another stray sequence arrives, and drops only on an end-of-active-video sequence once the hold has run out. While the framing enable input is high, every detected sequence re-aligns the counter to itself; while it is low the counter keeps its phase.

Top module: `svm_sync_monitor`

## Requirements
- R1: A sequence is three words 3FFh, 000h, 000h followed by a status word; `eav_o` pulses for one cycle when that status word has bit 6 = 1, `sav_o` when bit 6 = 0, in the cycle that `data_o` carries the status word; `data_o` is `data_i` delayed by one clock.
- R2: While `rst_ni` is low all outputs are 0 and the monitor holds no lock.
- R3: The first sequence seen without lock (after reset or after lock loss) sets `nsp_o` one cycle after its status word is on `data_i`.
- R4: A sequence whose type does not match the counter's prediction for its position (end at 0, start at `SAV_POS`) sets `nsp_o`.
- R5: Once set, `nsp_o` stays 1 for at least `LINE_LEN` cycles; an end-of-active-video sequence arriving exactly `LINE_LEN` cycles after the setting one clears it, so the high time is exactly `LINE_LEN` cycles.
- R6: A further stray sequence while `nsp_o` is 1 restarts the full `LINE_LEN` hold, so an end sequence that would have cleared the first hold does not clear it.
- R7: After the hold has run out, `nsp_o` falls only in the cycle after an end-of-active-video sequence; start sequences never clear it.
- R8: With `frame_en_i` low a detected sequence does not move the counter: after a stray sequence, correctly placed lines raise no new flag.
- R9: With `frame_en_i` high a detected sequence re-aligns the counter, so lines in the new phase raise no further flag.
- R10: If no end-of-active-video sequence arrives at position 0 while locked, lock is lost and the next sequence sets `nsp_o` as new.
- R11: The counter wraps at `LINE_LEN` words: back-to-back correctly placed lines never set `nsp_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 10 | Incoming video word |
| frame_en_i | input | 1 | Allow detected sequences to re-align the line counter |
| data_o | output | 10 | Input word delayed by one clock |
| eav_o | output | 1 | End-of-active-video status word on `data_o` |
| sav_o | output | 1 | Start-of-active-video status word on `data_o` |
| nsp_o | output | 1 | Sticky new or out-of-place sequence flag |

## Verification
The hold timer running out and an end-of-active-video sequence clearing the flag can fall in the same cycle. The bench provokes this by cutting a line short with framing enabled, so a stray end sequence re-aligns the counter and the next end sequence lands exactly one line length later; the flag must then be high for exactly `LINE_LEN` cycles. A retrigger in the same window as a would-be clear is also driven, where the flag must stay up past the end sequence. A cycle-accurate reference model run beside the design judges every output on every word.

// File: rtl/svm_pkg.sv
package svm_pkg;
  localparam int WORD_W      = 10;
  localparam int TRS_PRE_LEN = 3;
  localparam int XYZ_H_BIT   = 6;

  typedef enum logic [1:0] {
    TRS_NONE = 2'd0,
    TRS_EAV  = 2'd1,
    TRS_SAV  = 2'd2
  } trs_kind_e;
endpackage

// File: rtl/svm_trs_detect.sv
module svm_trs_detect
  import svm_pkg::*;
#(
  parameter int WORD_W  = svm_pkg::WORD_W,
  parameter int PRE_LEN = svm_pkg::TRS_PRE_LEN,
  parameter int H_BIT   = svm_pkg::XYZ_H_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  output trs_kind_e         kind_o
);
  // hist_q[0] is the newest past word, hist_q[PRE_LEN-1] the oldest
  logic [WORD_W-1:0] hist_q [PRE_LEN];
  logic [PRE_LEN-1:0] stage_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < PRE_LEN; k++) hist_q[k] <= '0;
    end else begin
      hist_q[0] <= data_i;
      for (int k = 1; k < PRE_LEN; k++) hist_q[k] <= hist_q[k-1];
    end
  end

  generate
    for (genvar k = 0; k < PRE_LEN; k++) begin : g_stage
      if (k == PRE_LEN - 1) begin : g_ones
        assign stage_ok[k] = (hist_q[k] == '1);
      end else begin : g_zero
        assign stage_ok[k] = (hist_q[k] == '0);
      end
    end
  endgenerate

  always_comb begin
    kind_o = TRS_NONE;
    if (&stage_ok) kind_o = data_i[H_BIT] ? TRS_EAV : TRS_SAV;
  end
endmodule

// File: rtl/svm_line_pos.sv
module svm_line_pos
  import svm_pkg::*;
#(
  parameter int LINE_LEN = 64,
  parameter int SAV_POS  = 20,
  localparam int PW      = $clog2(LINE_LEN)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  trs_kind_e kind_i,
  input  logic      frame_en_i,
  output logic      in_place_o,
  output logic      locked_o
);
  localparam logic [PW-1:0] LAST     = PW'(LINE_LEN - 1);
  localparam logic [PW-1:0] SAV_AT   = PW'(SAV_POS);
  localparam logic [PW-1:0] EAV_NEXT = PW'((LINE_LEN > 1) ? 1 : 0);
  localparam logic [PW-1:0] SAV_NEXT = PW'((SAV_POS + 1 >= LINE_LEN) ? 0 : SAV_POS + 1);

  logic [PW-1:0] pos_q, pos_d;
  logic          lock_q, lock_d;
  logic          eav_missing;

  assign in_place_o = lock_q &&
                      ((kind_i == TRS_EAV && pos_q == '0) ||
                       (kind_i == TRS_SAV && pos_q == SAV_AT));
  assign eav_missing = lock_q && (pos_q == '0) && (kind_i != TRS_EAV);
  assign locked_o = lock_q;

  always_comb begin
    pos_d  = (pos_q == LAST) ? '0 : pos_q + 1'b1;
    lock_d = lock_q;
    if (kind_i != TRS_NONE && frame_en_i) begin
      pos_d  = (kind_i == TRS_EAV) ? EAV_NEXT : SAV_NEXT;
      lock_d = 1'b1;
    end else if (eav_missing) begin
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      lock_q <= lock_d;
    end
  end
endmodule

// File: rtl/svm_nsp_hold.sv
module svm_nsp_hold #(
  parameter int LINE_LEN = 64,
  localparam int TW      = $clog2(LINE_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic eav_i,
  output logic nsp_o
);
  localparam logic [TW-1:0] RELOAD = TW'(LINE_LEN - 1);

  logic [TW-1:0] tmr_q;
  logic          nsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nsp_q <= 1'b0;
      tmr_q <= '0;
    end else if (trig_i) begin
      nsp_q <= 1'b1;
      tmr_q <= RELOAD;
    end else begin
      if (nsp_q && tmr_q == '0 && eav_i) nsp_q <= 1'b0;
      if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
    end
  end

  assign nsp_o = nsp_q;
endmodule

// File: rtl/svm_sync_monitor.sv
module svm_sync_monitor
  import svm_pkg::*;
#(
  parameter int WORD_W   = svm_pkg::WORD_W,
  parameter int LINE_LEN = 64,
  parameter int SAV_POS  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic              frame_en_i,
  output logic [WORD_W-1:0] data_o,
  output logic              eav_o,
  output logic              sav_o,
  output logic              nsp_o
);
  trs_kind_e trs_kind;
  logic      in_place;
  logic      locked;
  logic      trs_hit, trs_eav, nsp_trig;

  svm_trs_detect #(.WORD_W(WORD_W)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .kind_o (trs_kind)
  );

  svm_line_pos #(.LINE_LEN(LINE_LEN), .SAV_POS(SAV_POS)) u_pos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kind_i     (trs_kind),
    .frame_en_i (frame_en_i),
    .in_place_o (in_place),
    .locked_o   (locked)
  );

  assign trs_hit  = (trs_kind != TRS_NONE);
  assign trs_eav  = (trs_kind == TRS_EAV);
  assign nsp_trig = trs_hit && !in_place;

  svm_nsp_hold #(.LINE_LEN(LINE_LEN)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (nsp_trig),
    .eav_i  (trs_eav),
    .nsp_o  (nsp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      eav_o  <= 1'b0;
      sav_o  <= 1'b0;
    end else begin
      data_o <= data_i;
      eav_o  <= trs_eav;
      sav_o  <= trs_hit && !trs_eav;
    end
  end
endmodule

// File: rtl/svm_sync_monitor_chk.sv
module svm_sync_monitor_chk #(
  parameter int LINE_LEN = 64,
  localparam int CW      = $clog2(LINE_LEN + 2)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic eav_o,
  input logic sav_o,
  input logic nsp_o,
  input logic trs_hit,
  input logic trs_eav,
  input logic nsp_trig
);
  // cycles since the last trigger, 0 once the minimum hold is over
  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_cnt <= '0;
    else if (nsp_trig) hold_cnt <= CW'(1);
    else if (hold_cnt == CW'(LINE_LEN)) hold_cnt <= '0;
    else if (hold_cnt != '0) hold_cnt <= hold_cnt + 1'b1;
  end

  a_r1_eav_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trs_hit && trs_eav) |=> eav_o);
  a_r1_sav_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trs_hit && !trs_eav) |=> sav_o);
  a_r1_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eav_o && sav_o));
  a_r4_trig_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nsp_trig |=> nsp_o);
  a_r5_min_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_cnt != '0) |-> nsp_o);
  a_r7_clear_by_eav: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nsp_o) |-> $past(trs_hit && trs_eav));
endmodule

bind svm_sync_monitor svm_sync_monitor_chk #(.LINE_LEN(LINE_LEN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .eav_o    (eav_o),
  .sav_o    (sav_o),
  .nsp_o    (nsp_o),
  .trs_hit  (trs_hit),
  .trs_eav  (trs_eav),
  .nsp_trig (nsp_trig)
);

// File: tb/svm_sync_monitor_bench.sv
`timescale 1ns/1ps
module svm_sync_monitor_bench;
  localparam int LINE_LEN = 64;
  localparam int SAV_POS  = 20;
  localparam logic [9:0] FILL    = 10'h200;
  localparam logic [9:0] EAV_XYZ = 10'h274;  // bit 6 = 1
  localparam logic [9:0] SAV_XYZ = 10'h2AC;  // bit 6 = 0

  logic       clk_i = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] data_i = FILL;
  logic       frame_en = 1'b1;
  logic [9:0] data_o;
  logic       eav_o, sav_o, nsp_o;

  always #10 clk_i = ~clk_i;

  svm_sync_monitor #(.LINE_LEN(LINE_LEN), .SAV_POS(SAV_POS)) u_svm_sync_monitor (
    .clk_i(clk_i), .rst_ni(rst_n), .data_i(data_i), .frame_en_i(frame_en),
    .data_o(data_o), .eav_o(eav_o), .sav_o(sav_o), .nsp_o(nsp_o)
  );

  int checks = 0, failures = 0;
  int eav_cnt, sav_cnt, nsp_hi, nsp_rise;
  logic nsp_prev;

  // reference model
  logic [9:0] m_w1, m_w2, m_w3, m_data;
  int m_pos, m_tmr;
  logic m_sync, m_nsp, m_eav, m_sav;
  logic hit, ev, sv, expd, trig, miss;

  always @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      m_w1 = 0; m_w2 = 0; m_w3 = 0; m_data = 0; m_pos = 0; m_tmr = 0;
      m_sync = 0; m_nsp = 0; m_eav = 0; m_sav = 0;
    end else begin
      hit  = (m_w3 == 10'h3FF) && (m_w2 == 0) && (m_w1 == 0);
      ev   = hit && data_i[6];
      sv   = hit && !data_i[6];
      expd = m_sync && ((ev && m_pos == 0) || (sv && m_pos == SAV_POS));
      trig = hit && !expd;
      miss = m_sync && (m_pos == 0) && !ev;
      if (trig) begin m_nsp = 1; m_tmr = LINE_LEN - 1; end
      else begin
        if (m_nsp && m_tmr == 0 && ev) m_nsp = 0;
        if (m_tmr > 0) m_tmr = m_tmr - 1;
      end
      if (hit && frame_en) begin m_pos = ev ? 1 : SAV_POS + 1; m_sync = 1; end
      else begin
        m_pos = (m_pos == LINE_LEN - 1) ? 0 : m_pos + 1;
        if (miss) m_sync = 0;
      end
      m_w3 = m_w2; m_w2 = m_w1; m_w1 = data_i;
      m_eav = ev; m_sav = sv; m_data = data_i;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] line_word(int p, int xpos, bit drop_tail);
    if (drop_tail && p >= LINE_LEN - 3) return FILL;
    if (xpos > 0) begin
      if (p == xpos - 3) return 10'h3FF;
      if (p == xpos - 2 || p == xpos - 1) return 10'h000;
      if (p == xpos) return SAV_XYZ;
    end
    if (p == 0) return EAV_XYZ;
    if (p == SAV_POS) return SAV_XYZ;
    if (p == LINE_LEN - 3 || p == SAV_POS - 3) return 10'h3FF;
    if (p == LINE_LEN - 2 || p == LINE_LEN - 1 || p == SAV_POS - 2 || p == SAV_POS - 1)
      return 10'h000;
    return FILL;
  endfunction

  // compare with the model, then drive the next word
  task automatic send_word(input logic [9:0] w, input string tag);
    @(negedge clk_i);
    check(data_o == m_data, {tag, " R1 data_o"}, data_o, m_data);
    check({eav_o, sav_o} == {m_eav, m_sav}, {tag, " R1 eav/sav"}, {eav_o, sav_o}, {m_eav, m_sav});
    check(nsp_o == m_nsp, {tag, " nsp model"}, nsp_o, m_nsp);
    eav_cnt += eav_o; sav_cnt += sav_o; nsp_hi += nsp_o;
    if (nsp_o && !nsp_prev) nsp_rise++;
    nsp_prev = nsp_o;
    data_i = w;
  endtask

  task automatic run_words(input int from, input int to, input int xpos, input bit drop, input string tag);
    for (int p = from; p <= to; p++) send_word(line_word(p, xpos, drop), tag);
  endtask

  task automatic clr_cnt();
    eav_cnt = 0; sav_cnt = 0; nsp_hi = 0; nsp_rise = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; nsp_prev = 1'b0;
    repeat (3) @(negedge clk_i);
    check({data_o, eav_o, sav_o, nsp_o} == 0, "R2 reset outputs", {data_o, eav_o, sav_o, nsp_o}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_lock();
    frame_en = 1'b1; clr_cnt();
    run_words(0, LINE_LEN - 1, 0, 0, "R3 lock");
    check(nsp_o == 1, "R3 first sequence flagged new", nsp_o, 1);
    for (int l = 0; l < 3; l++) run_words(0, LINE_LEN - 1, 0, 0, "R11 lock");
    check(eav_cnt == 3, "R1 eav pulse count", eav_cnt, 3);
    check(sav_cnt == 4, "R1 sav pulse count", sav_cnt, 4);
    check(nsp_hi == 2 * LINE_LEN - SAV_POS, "R5 hold from new", nsp_hi, 2 * LINE_LEN - SAV_POS);
    check(nsp_rise == 1, "R11 clean lines raise nothing", nsp_rise, 1);
    check(nsp_o == 0, "R7 cleared by eav", nsp_o, 0);
  endtask

  task automatic t_misplaced();
    frame_en = 1'b0; clr_cnt();
    run_words(0, LINE_LEN - 1, 50, 0, "R4 stray");
    check(nsp_o == 1, "R4 stray sequence flagged", nsp_o, 1);
    for (int l = 0; l < 3; l++) run_words(0, LINE_LEN - 1, 0, 0, "R8 no realign");
    check(nsp_rise == 1, "R8 phase kept", nsp_rise, 1);
    check(nsp_hi == 2 * LINE_LEN - 50, "R7 clear at first eav after hold", nsp_hi, 2 * LINE_LEN - 50);
    check(nsp_o == 0, "R7 flag low", nsp_o, 0);
  endtask

  task automatic t_retrigger();
    frame_en = 1'b0; clr_cnt();
    run_words(0, LINE_LEN - 1, 50, 0, "R6 first");
    run_words(0, LINE_LEN - 1, 40, 0, "R6 second");
    run_words(0, 1, 0, 0, "R6 eav");
    check(nsp_o == 1, "R6 retrigger outlasts eav", nsp_o, 1);
    run_words(2, LINE_LEN - 1, 0, 0, "R6 tail");
    run_words(0, LINE_LEN - 1, 0, 0, "R7 clear");
    check(nsp_o == 0, "R7 clear after retriggered hold", nsp_o, 0);
    check(nsp_rise == 1, "R6 single rise", nsp_rise, 1);
  endtask

  task automatic t_realign();
    frame_en = 1'b1; clr_cnt();
    run_words(0, 49, 0, 0, "R9 short");
    run_words(LINE_LEN - 3, LINE_LEN - 1, 0, 0, "R9 early eav");
    run_words(0, LINE_LEN - 1, 0, 0, "R9 line");
    run_words(0, LINE_LEN - 1, 0, 0, "R9 line");
    check(nsp_hi == LINE_LEN, "R5 hold expiry meets eav", nsp_hi, LINE_LEN);
    check(nsp_rise == 1, "R9 new phase accepted", nsp_rise, 1);
    check(nsp_o == 0, "R9 flag low", nsp_o, 0);
  endtask

  task automatic t_missing();
    frame_en = 1'b1; clr_cnt();
    run_words(0, LINE_LEN - 1, 0, 1, "R10 drop");
    run_words(0, SAV_POS + 1, 0, 0, "R10 after");
    check(nsp_o == 1, "R10 sequence after loss flagged", nsp_o, 1);
    check(nsp_rise == 1, "R10 single rise", nsp_rise, 1);
    run_words(SAV_POS + 2, LINE_LEN - 1, 0, 0, "R10 tail");
    for (int l = 0; l < 2; l++) run_words(0, LINE_LEN - 1, 0, 0, "R10 relock");
    check(nsp_o == 0, "R10 relocked and cleared", nsp_o, 0);
  endtask

  initial begin
    #(20ns * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_lock();
    t_misplaced();
    t_retrigger();
    t_realign();
    t_missing();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule